// File: doc/BRIEF.md
# USB Battery-Charging Port Classifier

This block decides what sort of upstream port a USB device has been plugged into. It watches two inputs: one says that bus power is present and the other carries the level of the cable's identification pin. While power is present it runs three timed measurement phases on the data lines. The first is a data-contact check, the second a primary detection and the third a secondary detection. For each phase it drives three configuration bytes to an analog front end. These bytes switch the current sources, voltage sources, sinks and comparator references on the D+ and D- lines. At the end of each wait it reads an 8-bit comparator status word and applies that phase's own pass rule.

The outcome is a 2-bit port code with a one-cycle valid pulse. The code tells apart a standard downstream port, a charging downstream port and a dedicated charger. The block also raises a device-connect flag when data enumeration can follow, a host-connect flag when the identification pin is grounded, and a PHY enable that frames the whole measurement. All timing counts a 1 ms tick input, so the same logic works at any core clock. A contact check that never succeeds within its budget is reported as a dedicated charger. A grounded identification pin wins over bus power and puts the block in host role.

Top module: `chg_det_seq`

## Requirements
- R1: After reset phyEn, devConnect, hostConnect and resultValid are 0, resultCode is 0 (none) and ctrlA, ctrlB and intrCtl are 0x00.
- R2: While idle, idHigh low asserts hostConnect at the next clock edge, even when vbusOn is high, and phyEn stays 0 in host role.
- R3: In host role, idHigh returning high clears hostConnect at the next edge. The block then goes back to idle, where it re-evaluates its inputs.
- R4: While idle with idHigh high, vbusOn high sets phyEn at the next edge with ctrlA=0x08, ctrlB=0x01 and intrCtl=0x1F, and starts the contact check. Whenever phyEn is 0, all three bytes are 0x00.
- R5: The contact check samples lineStat every 50 ticks. It passes when lineStat is any value except exactly 0x01, and the block then drives ctrlA=0x25, ctrlB=0x00 and intrCtl=0x1F. On a failed sample it keeps the contact-check bytes.
- R6: Each failed contact sample adds 50 to an elapsed count that starts at 0. A failed sample taken when the count is already 750 or more (the 16th consecutive failure, 800 ticks after entry) yields code 3 with devConnect low.
- R7: Primary detection samples lineStat 100 ticks after it starts. A value that is nonzero and not 0x01 moves to secondary detection with ctrlA=0x72, ctrlB=0x00 and intrCtl=0x1F. Any other value yields code 1 (standard port) and sets devConnect.
- R8: Secondary detection samples lineStat 100 ticks after it starts. A nonzero value yields code 3 (dedicated charger) with devConnect low. Zero yields code 2 (charging port) and sets devConnect.
- R9: resultValid is high for exactly one cycle. It rises on the edge where resultCode takes its new value, and phyEn drops to 0 and all bytes go to 0x00 on that same edge.
- R10: vbusOn low during any measurement phase clears phyEn and the bytes at the next edge without giving a result. The block returns to idle one cycle later.
- R11: After a result, vbusOn low clears devConnect and sets resultCode to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickMs | input | 1 | One-cycle pulse every millisecond |
| vbusOn | input | 1 | Bus power present |
| idHigh | input | 1 | Identification pin level; low selects host role |
| lineStat | input | 8 | Data-line comparator status word |
| phyEn | output | 1 | Enables the PHY analog front end for measurement |
| ctrlA | output | 8 | First source/sink configuration byte |
| ctrlB | output | 8 | Second source/sink configuration byte |
| intrCtl | output | 8 | Comparator interrupt-control byte |
| devConnect | output | 1 | Device data connection may enumerate |
| hostConnect | output | 1 | Host role selected |
| resultCode | output | 2 | 0 none, 1 standard, 2 charging port, 3 dedicated charger |
| resultValid | output | 1 | One-cycle pulse when resultCode is updated |

## Verification
Each phase is tied to a distinct set of configuration bytes, so a wrong internal phase shows on ctrlA and ctrlB at the very next clock edge. A slip in the tick timer or the elapsed count moves the result pulse by whole ticks, and the bench catches this because it compares every cycle against a behavioural model. A mix-up in a phase's pass rule shows as the wrong resultCode. The boundary status values 0x00 and 0x01 are applied in each phase, so the rules cannot be swapped unnoticed. A stuck role shows within one cycle as a connect flag that fails to follow vbusOn or idHigh.

// File: rtl/chg_det_pkg.sv
package chg_det_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DISC, ST_DCD, ST_PRI, ST_SEC, ST_DONE, ST_HOST
  } seqState_t;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0, RES_SDP = 2'd1, RES_CDP = 2'd2, RES_DCP = 2'd3
  } chgCode_t;

  typedef enum logic [1:0] {
    CFG_OFF, CFG_DCD, CFG_PRI, CFG_SEC
  } phaseCfg_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic      loadCfg;
    phaseCfg_t cfg;
    logic      timerClr;
    logic      elapsedClr;
    logic      elapsedAdd;
    logic      setDev;
    logic      clrDev;
    logic      setHost;
    logic      clrHost;
    logic      publish;
    chgCode_t  code;
    logic      clrCode;
  } seqStrobe_t;

endpackage

// File: rtl/chg_det_ctrl.sv
module chg_det_ctrl
  import chg_det_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       vbusOn,
  input  logic       idHigh,
  input  logic       timerDone,
  input  logic       dcdPass,
  input  logic       priPass,
  input  logic       secPass,
  input  logic       elapsedFull,
  output seqStrobe_t strb
);

  seqState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strb = '0;
    strb.cfg = CFG_OFF;
    strb.code = RES_NONE;
    unique case (stateQ)
      ST_IDLE: begin
        if (!idHigh) begin
          strb.setHost = 1'b1;
          stateD = ST_HOST;
        end else if (vbusOn) begin
          strb.loadCfg = 1'b1;
          strb.cfg = CFG_DCD;
          strb.timerClr = 1'b1;
          strb.elapsedClr = 1'b1;
          stateD = ST_DCD;
        end
      end
      ST_DISC: begin
        strb.loadCfg = 1'b1;
        strb.cfg = CFG_OFF;
        stateD = ST_IDLE;
      end
      ST_DCD: begin
        if (!vbusOn) begin
          strb.loadCfg = 1'b1;
          stateD = ST_DISC;
        end else if (timerDone) begin
          if (dcdPass) begin
            strb.loadCfg = 1'b1;
            strb.cfg = CFG_PRI;
            strb.timerClr = 1'b1;
            stateD = ST_PRI;
          end else if (!elapsedFull) begin
            strb.elapsedAdd = 1'b1;
            strb.timerClr = 1'b1;
          end else begin
            strb.loadCfg = 1'b1;
            strb.publish = 1'b1;
            strb.code = RES_DCP;
            stateD = ST_DONE;
          end
        end
      end
      ST_PRI: begin
        if (!vbusOn) begin
          strb.loadCfg = 1'b1;
          stateD = ST_DISC;
        end else if (timerDone) begin
          if (priPass) begin
            strb.loadCfg = 1'b1;
            strb.cfg = CFG_SEC;
            strb.timerClr = 1'b1;
            stateD = ST_SEC;
          end else begin
            strb.loadCfg = 1'b1;
            strb.publish = 1'b1;
            strb.code = RES_SDP;
            strb.setDev = 1'b1;
            stateD = ST_DONE;
          end
        end
      end
      ST_SEC: begin
        if (!vbusOn) begin
          strb.loadCfg = 1'b1;
          stateD = ST_DISC;
        end else if (timerDone) begin
          strb.loadCfg = 1'b1;
          strb.publish = 1'b1;
          strb.code = secPass ? RES_DCP : RES_CDP;
          strb.setDev = !secPass;
          stateD = ST_DONE;
        end
      end
      ST_DONE: begin
        if (!vbusOn) begin
          strb.clrDev = 1'b1;
          strb.clrCode = 1'b1;
          stateD = ST_IDLE;
        end
      end
      ST_HOST: begin
        if (idHigh) begin
          strb.clrHost = 1'b1;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  // R10
  disc_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ST_DISC |=> stateQ == ST_IDLE);

  // R2
  host_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !idHigh) |=> stateQ == ST_HOST);

endmodule

// File: rtl/chg_det_dpath.sv
module chg_det_dpath
  import chg_det_pkg::*;
#(
  parameter int CTRL_W       = 8,
  parameter int STAT_W       = 8,
  parameter int DCD_POLL_MS  = 50,
  parameter int DCD_LIMIT_MS = 750,
  parameter int PRI_WAIT_MS  = 100,
  parameter int SEC_WAIT_MS  = 100,
  parameter logic [CTRL_W-1:0] DCD_A  = 8'h08,
  parameter logic [CTRL_W-1:0] DCD_B  = 8'h01,
  parameter logic [CTRL_W-1:0] PRI_A  = 8'h25,
  parameter logic [CTRL_W-1:0] SEC_A  = 8'h72,
  parameter logic [CTRL_W-1:0] INTR_V = 8'h1F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickMs,
  input  logic [STAT_W-1:0] lineStat,
  input  seqStrobe_t        strb,
  output logic              timerDone,
  output logic              dcdPass,
  output logic              priPass,
  output logic              secPass,
  output logic              elapsedFull,
  output logic              phyEn,
  output logic [CTRL_W-1:0] ctrlA,
  output logic [CTRL_W-1:0] ctrlB,
  output logic [CTRL_W-1:0] intrCtl,
  output logic              devConnect,
  output logic              hostConnect,
  output logic [1:0]        resultCode,
  output logic              resultValid
);

  localparam int MAX_WAIT = (DCD_POLL_MS > PRI_WAIT_MS)
                          ? ((DCD_POLL_MS > SEC_WAIT_MS) ? DCD_POLL_MS : SEC_WAIT_MS)
                          : ((PRI_WAIT_MS > SEC_WAIT_MS) ? PRI_WAIT_MS : SEC_WAIT_MS);
  localparam int TMR_W = $clog2(MAX_WAIT + 1);
  localparam int EL_W  = $clog2(DCD_LIMIT_MS + DCD_POLL_MS + 1);
  localparam logic [STAT_W-1:0] DP_ONLY = STAT_W'(1);

  logic [TMR_W-1:0] timerCnt, waitLen;
  logic [EL_W-1:0]  elapsedMs;

  // status decode, one rule per phase
  assign dcdPass     = lineStat != DP_ONLY;
  assign priPass     = (lineStat != '0) && (lineStat != DP_ONLY);
  assign secPass     = lineStat != '0;
  assign timerDone   = tickMs && (timerCnt == waitLen - TMR_W'(1));
  assign elapsedFull = elapsedMs >= EL_W'(DCD_LIMIT_MS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerCnt  <= '0;
      waitLen   <= TMR_W'(DCD_POLL_MS);
      elapsedMs <= '0;
    end else begin
      if (strb.timerClr)  timerCnt <= '0;
      else if (tickMs)    timerCnt <= timerCnt + TMR_W'(1);
      if (strb.loadCfg) begin
        unique case (strb.cfg)
          CFG_DCD: waitLen <= TMR_W'(DCD_POLL_MS);
          CFG_PRI: waitLen <= TMR_W'(PRI_WAIT_MS);
          CFG_SEC: waitLen <= TMR_W'(SEC_WAIT_MS);
          default: waitLen <= waitLen;
        endcase
      end
      if (strb.elapsedClr)      elapsedMs <= '0;
      else if (strb.elapsedAdd) elapsedMs <= elapsedMs + EL_W'(DCD_POLL_MS);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyEn   <= 1'b0;
      ctrlA   <= '0;
      ctrlB   <= '0;
      intrCtl <= '0;
    end else if (strb.loadCfg) begin
      phyEn   <= strb.cfg != CFG_OFF;
      intrCtl <= (strb.cfg != CFG_OFF) ? INTR_V : '0;
      ctrlB   <= (strb.cfg == CFG_DCD) ? DCD_B : '0;
      unique case (strb.cfg)
        CFG_DCD: ctrlA <= DCD_A;
        CFG_PRI: ctrlA <= PRI_A;
        CFG_SEC: ctrlA <= SEC_A;
        default: ctrlA <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devConnect  <= 1'b0;
      hostConnect <= 1'b0;
      resultCode  <= RES_NONE;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strb.publish;
      if (strb.publish)      resultCode <= strb.code;
      else if (strb.clrCode) resultCode <= RES_NONE;
      if (strb.setDev)       devConnect <= 1'b1;
      else if (strb.clrDev)  devConnect <= 1'b0;
      if (strb.setHost)      hostConnect <= 1'b1;
      else if (strb.clrHost) hostConnect <= 1'b0;
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R9
  valid_phy_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> !phyEn);

  // R4
  idle_bytes_chk: assert property (@(posedge clk) disable iff (!rstN)
    !phyEn |-> (ctrlA == '0 && ctrlB == '0 && intrCtl == '0));

  // R6
  elapsed_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    elapsedMs <= EL_W'(DCD_LIMIT_MS));

  // R2
  one_role_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(devConnect && hostConnect));

  // R7
  dev_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    devConnect |-> (resultCode == RES_SDP || resultCode == RES_CDP));

endmodule

// File: rtl/chg_det_seq.sv
module chg_det_seq
  import chg_det_pkg::*;
#(
  parameter int CTRL_W       = 8,
  parameter int STAT_W       = 8,
  parameter int DCD_POLL_MS  = 50,
  parameter int DCD_LIMIT_MS = 750,
  parameter int PRI_WAIT_MS  = 100,
  parameter int SEC_WAIT_MS  = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickMs,
  input  logic              vbusOn,
  input  logic              idHigh,
  input  logic [STAT_W-1:0] lineStat,
  output logic              phyEn,
  output logic [CTRL_W-1:0] ctrlA,
  output logic [CTRL_W-1:0] ctrlB,
  output logic [CTRL_W-1:0] intrCtl,
  output logic              devConnect,
  output logic              hostConnect,
  output logic [1:0]        resultCode,
  output logic              resultValid
);

  seqStrobe_t strb;
  logic timerDone, dcdPass, priPass, secPass, elapsedFull;

  chg_det_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .vbusOn(vbusOn), .idHigh(idHigh),
    .timerDone(timerDone), .dcdPass(dcdPass), .priPass(priPass),
    .secPass(secPass), .elapsedFull(elapsedFull), .strb(strb)
  );

  chg_det_dpath #(
    .CTRL_W(CTRL_W), .STAT_W(STAT_W), .DCD_POLL_MS(DCD_POLL_MS),
    .DCD_LIMIT_MS(DCD_LIMIT_MS), .PRI_WAIT_MS(PRI_WAIT_MS),
    .SEC_WAIT_MS(SEC_WAIT_MS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .tickMs(tickMs), .lineStat(lineStat),
    .strb(strb), .timerDone(timerDone), .dcdPass(dcdPass),
    .priPass(priPass), .secPass(secPass), .elapsedFull(elapsedFull),
    .phyEn(phyEn), .ctrlA(ctrlA), .ctrlB(ctrlB), .intrCtl(intrCtl),
    .devConnect(devConnect), .hostConnect(hostConnect),
    .resultCode(resultCode), .resultValid(resultValid)
  );

endmodule

// File: tb/sim_chg_det_seq.sv
module sim_chg_det_seq;

  localparam int POLL = 50, LIMIT = 750, PWAIT = 100, SWAIT = 100;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, tickMs = 1'b0, vbusOn = 1'b0, idHigh = 1'b1;
  logic [7:0] lineStat = 8'h00;
  logic phyEn, devConnect, hostConnect, resultValid;
  logic [7:0] ctrlA, ctrlB, intrCtl;
  logic [1:0] resultCode;

  logic [7:0] dcdVal = 8'h00, priVal = 8'h00, secVal = 8'h00;

  int checks = 0, errors = 0;

  chg_det_seq u0 (
    .clk(clk), .rstN(rstN), .tickMs(tickMs), .vbusOn(vbusOn), .idHigh(idHigh),
    .lineStat(lineStat), .phyEn(phyEn), .ctrlA(ctrlA), .ctrlB(ctrlB),
    .intrCtl(intrCtl), .devConnect(devConnect), .hostConnect(hostConnect),
    .resultCode(resultCode), .resultValid(resultValid)
  );

  // tick on every other cycle; analog stand-in answers per configuration
  always @(negedge clk) begin
    tickMs <= ~tickMs;
    case (ctrlA)
      8'h08:   lineStat <= dcdVal;
      8'h25:   lineStat <= priVal;
      8'h72:   lineStat <= secVal;
      default: lineStat <= 8'h00;
    endcase
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: 0 idle 1 gone 2 contact 3 primary 4 secondary 5 done 6 host
  int mSt, tcnt, wt, el, s;
  int mPhy, mA, mB, mI, mDev, mHost, mCode, mValid;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; tcnt = 0; wt = POLL; el = 0;
      mPhy = 0; mA = 0; mB = 0; mI = 0; mDev = 0; mHost = 0; mCode = 0; mValid = 0;
    end else begin
      mValid = 0;
      case (mSt)
        0: if (!idHigh) begin mHost = 1; mSt = 6; end
           else if (vbusOn) begin
             mPhy = 1; mA = 8'h08; mB = 8'h01; mI = 8'h1F;
             tcnt = 0; wt = POLL; el = 0; mSt = 2;
           end
        1: mSt = 0;
        2, 3, 4: begin
          if (!vbusOn) begin
            mPhy = 0; mA = 0; mB = 0; mI = 0; mSt = 1;
          end else if (tickMs) begin
            tcnt++;
            if (tcnt == wt) begin
              tcnt = 0;
              s = int'(lineStat);
              if (mSt == 2) begin
                if (s != 1) begin mA = 8'h25; mB = 0; wt = PWAIT; mSt = 3; end
                else if (el < LIMIT) el += POLL;
                else begin
                  mPhy = 0; mA = 0; mB = 0; mI = 0; mCode = 3; mValid = 1; mSt = 5;
                end
              end else if (mSt == 3) begin
                if (s != 0 && s != 1) begin mA = 8'h72; wt = SWAIT; mSt = 4; end
                else begin
                  mPhy = 0; mA = 0; mB = 0; mI = 0; mCode = 1; mDev = 1; mValid = 1; mSt = 5;
                end
              end else begin
                mPhy = 0; mA = 0; mB = 0; mI = 0; mValid = 1; mSt = 5;
                if (s != 0) mCode = 3;
                else begin mCode = 2; mDev = 1; end
              end
            end
          end
        end
        5: if (!vbusOn) begin mDev = 0; mCode = 0; mSt = 0; end
        6: if (idHigh) begin mHost = 0; mSt = 0; end
        default: mSt = 0;
      endcase
    end
  end

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rstN) begin
      check("R4 phyEn vs model", int'(phyEn), mPhy);
      check("R4 ctrlA vs model", int'(ctrlA), mA);
      check("R4 ctrlB vs model", int'(ctrlB), mB);
      check("R4 intrCtl vs model", int'(intrCtl), mI);
      check("R7 devConnect vs model", int'(devConnect), mDev);
      check("R2 hostConnect vs model", int'(hostConnect), mHost);
      check("R8 resultCode vs model", int'(resultCode), mCode);
      check("R9 resultValid vs model", int'(resultValid), mValid);
    end
  end

  task automatic wait_ctrl(input string tag, input logic [7:0] val);
    int n = 0;
    while (ctrlA != val && n < 4000) begin @(negedge clk); n++; end
    check(tag, int'(ctrlA), int'(val));
  endtask

  task automatic wait_result(input string tag, input int code, input int dev);
    int n = 0;
    while (!resultValid && n < 4000) begin @(negedge clk); n++; end
    check({tag, " valid seen"}, int'(resultValid), 1);
    check({tag, " code"}, int'(resultCode), code);
    check({tag, " devConnect"}, int'(devConnect), dev);
    check("R9 phyEn off at result", int'(phyEn), 0);
    check("R9 ctrlA cleared at result", int'(ctrlA), 0);
    @(negedge clk);
    check("R9 valid one cycle", int'(resultValid), 0);
  endtask

  task automatic unplug();
    vbusOn = 1'b0;
    @(negedge clk);
    check("R11 devConnect cleared", int'(devConnect), 0);
    check("R11 code cleared", int'(resultCode), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 phyEn reset", int'(phyEn), 0);
    check("R1 ctrlA reset", int'(ctrlA), 0);
    check("R1 intrCtl reset", int'(intrCtl), 0);
    check("R1 hostConnect reset", int'(hostConnect), 0);
    check("R1 code reset", int'(resultCode), 0);
    check("R1 valid reset", int'(resultValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // host role wins over power
    vbusOn = 1'b1; idHigh = 1'b0;
    @(negedge clk);
    check("R2 hostConnect set", int'(hostConnect), 1);
    repeat (20) @(negedge clk);
    check("R2 phyEn stays low in host", int'(phyEn), 0);
    idHigh = 1'b1;
    @(negedge clk);
    check("R3 hostConnect cleared", int'(hostConnect), 0);
    @(negedge clk);
    check("R4 phyEn on", int'(phyEn), 1);
    check("R4 ctrlA contact", int'(ctrlA), 8'h08);
    check("R4 ctrlB contact", int'(ctrlB), 8'h01);
    check("R4 intrCtl contact", int'(intrCtl), 8'h1F);
    // contact 0x00 passes, primary 0x00 fails -> standard port
    wait_ctrl("R5 primary config", 8'h25);
    check("R5 ctrlB primary", int'(ctrlB), 0);
    check("R5 intrCtl primary", int'(intrCtl), 8'h1F);
    wait_result("R7 standard port", 1, 1);
    unplug();

    // charging port: two failed contact polls first
    dcdVal = 8'h01; priVal = 8'h02; secVal = 8'h00;
    vbusOn = 1'b1;
    repeat (250) @(negedge clk);
    check("R5 failed poll keeps contact config", int'(ctrlA), 8'h08);
    dcdVal = 8'h03;
    wait_ctrl("R7 secondary config", 8'h72);
    check("R7 intrCtl secondary", int'(intrCtl), 8'h1F);
    wait_result("R8 charging port", 2, 1);
    unplug();

    // dedicated charger via secondary
    dcdVal = 8'h80; priVal = 8'h04; secVal = 8'h01;
    vbusOn = 1'b1;
    wait_result("R8 dedicated via secondary", 3, 0);
    unplug();

    // primary boundary value 0x01 fails
    dcdVal = 8'h00; priVal = 8'h01;
    vbusOn = 1'b1;
    wait_result("R7 primary 0x01 fails", 1, 1);
    unplug();

    // contact timeout
    begin
      int n = 0;
      dcdVal = 8'h01;
      vbusOn = 1'b1;
      while (!resultValid && n < 4000) begin @(negedge clk); n++; end
      check("R6 timeout near 800 ticks", int'(n > 1580 && n < 1620), 1);
      check("R6 timeout code", int'(resultCode), 3);
      check("R6 timeout no devConnect", int'(devConnect), 0);
      unplug();
    end

    // power lost during primary
    dcdVal = 8'h00; priVal = 8'h04;
    vbusOn = 1'b1;
    wait_ctrl("R10 reach primary", 8'h25);
    vbusOn = 1'b0;
    @(negedge clk);
    check("R10 phyEn off", int'(phyEn), 0);
    check("R10 ctrlA off", int'(ctrlA), 0);
    check("R10 no result", int'(resultValid), 0);
    repeat (5) @(negedge clk);
    check("R10 code none", int'(resultCode), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule